// File: doc/BRIEF.md
# Banked System Interrupt Router

The router collects level-sensitive interrupt lines from peripherals and turns them into requests for the nine lower-priority event groups of a processor core. The lines are arranged in banks of 32. A parameter sets the number of banks to one, two or three. Each bank keeps a status word that copies the line levels, a mask word, a wakeup word and four assignment words. The assignment words hold one 4-bit group number for each line.

A line is pending when its status bit and its mask bit are both set. Every pending line raises the core group its assignment field names. The group outputs are the registered OR of all pending lines, taken across every bank. Software configures the router through a small word-oriented register bus. Each request on that bus gets a registered response one cycle later. The response carries the read data and an access-error flag.

Top module: `irq_router`

## Requirements
- R1: `NUM_BANKS` selects 1, 2 or 3 banks of 32 lines. Line n of bank b is `irq_in[b*32+n]`. Every bank has its own mask, status, wakeup and four assignment registers.
- R2: The status bit of each line equals the level that line had at the previous clock edge. It is set while the line is high and cleared once the line is low.
- R3: Status registers are read-only. A bus write to one completes without error and leaves the read-back value unchanged.
- R4: A line is forwarded only while both its status bit and its mask bit are 1. A masked or low line raises nothing.
- R5: Line n of a bank uses assignment register n/8 of that bank, bits [(n mod 8)*4+3 : (n mod 8)*4]. A field value v in 0..8 raises `grp_out[v]`, which stands for core group 7+v.
- R6: Assignment values 9 to 15 route the line to no output.
- R7: `grp_out` changes one clock after a change of status, mask or assignment. It therefore changes two clocks after a change on `irq_in`.
- R8: After reset, masks and status are 0 and wakeup registers are 0xFFFFFFFF. Bank 0 assignment words 0..3 are 0x22211000, 0x43333332, 0x55555444 and 0x66655555. The assignment words of the other banks are 0. `grp_out` and `bus_err` are 0.
- R9: Word index w = `bus_addr[7:2]`. Indexes 0..2 are control words. Bank b occupies indexes 3+8b .. 10+8b, in this order: mask, assignment 0..3, status, wakeup, and one unused slot. This gives bank 0 at byte offsets 0x0C, 0x10-0x1C, 0x20, 0x24 and 0x28.
- R10: `bus_size` codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. Only codes 1 and 2 with `bus_addr[1:0]==0` are accepted. Any other request sets `bus_err` in the next cycle, writes nothing and returns 0. Writes always return 0 read data.
- R11: A 16-bit write stores its low 16 data bits, zero-extended, into the 32-bit register. A 16-bit read returns the low 16 bits of the register, zero-extended.
- R12: Control word 2 reads `REV_ID`. Control words 0 and 1 read 0, as do unused slots and indexes beyond the last bank. Writes to any of these change nothing and raise no error.
- R13: Lines in different banks that name the same group are ORed into that one output. The output stays high while any of them is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Peripheral interrupt levels, bank-major |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code (1 = 16-bit, 2 = 32-bit) |
| bus_addr | input | ADDR_W | Byte address within the router |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_err | output | 1 | Access error, the cycle after the request |
| grp_out | output | 9 | Core group requests; bit k is group 7+k |

## Verification
The assertions assume that `irq_in` is a set of plain synchronous levels, each held for whole clock cycles. They also assume that a bus request lasts exactly one cycle and that the next request comes only after its response has been sampled. The bench drives every input on the falling clock edge and issues accesses one at a time through a task that waits for the response. Its random phase draws new line levels once per cycle and keeps all register writes on mask and assignment slots, so the quiet-output and error-response properties only ever see legal, single-cycle requests.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, selector encodings and reset map for the
// banked interrupt router. Assumes 32-bit registers and 4-bit routing fields.
package irq_router_pkg;

    localparam int LINES_PER_BANK  = 32;
    localparam int FIELD_W         = 4;
    localparam int ASSIGN_WORDS    = 4;
    localparam int GROUP_COUNT     = 9;
    localparam int CTRL_WORDS      = 3;
    localparam int REV_WORD        = 2;
    localparam int BANK_SLOTS      = 8;
    localparam int FIELD_BITS      = LINES_PER_BANK * FIELD_W;

    // Register slot inside one bank window
    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_ASG0   = 3'd1,
        SEL_ASG1   = 3'd2,
        SEL_ASG2   = 3'd3,
        SEL_ASG3   = 3'd4,
        SEL_STATUS = 3'd5,
        SEL_WAKE   = 3'd6,
        SEL_NONE   = 3'd7
    } bank_sel_e;

    // Bus access width code
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Reset value of one assignment word; only bank 0 has a non-zero map
    function automatic logic [31:0] assign_reset(input int bank, input int word);
        logic [31:0] v;
        v = 32'h0;
        if (bank == 0) begin
            case (word)
                0:       v = 32'h2221_1000;
                1:       v = 32'h4333_3332;
                2:       v = 32'h5555_5444;
                3:       v = 32'h6665_5555;
                default: v = 32'h0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_bank_regs.sv
// Module: one bank of 32 interrupt lines. Holds the level-tracking status,
// the mask, the wakeup word and four assignment words; produces the pending
// vector and the packed routing fields. Assumes one write strobe per cycle
// from the bus decoder and that status is never writable.
module irq_bank_regs
    import irq_router_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           irq_lvl,
    input  logic                  wr_en,
    input  bank_sel_e             sel,
    input  logic [31:0]           wr_word,
    output logic [31:0]           rd_word,
    output logic [31:0]           pending,
    output logic [FIELD_BITS-1:0] assign_flat
);

    logic [31:0] status_q;
    logic [31:0] mask_q;
    logic [31:0] wake_q;
    logic [31:0] asg_q [ASSIGN_WORDS];

    // Status copies the line levels every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= irq_lvl;
    end

    // Mask and wakeup words are written by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_q <= '1;
        end else if (wr_en) begin
            if (sel == SEL_MASK) mask_q <= wr_word;
            if (sel == SEL_WAKE) wake_q <= wr_word;
        end
    end

    // Assignment words reset to the bank's default map
    always_ff @(posedge clk) begin
        for (int w = 0; w < ASSIGN_WORDS; w++) begin
            if (!rst_n)
                asg_q[w] <= assign_reset(BANK_ID, w);
            else if (wr_en && (sel == bank_sel_e'(3'(w + 1))))
                asg_q[w] <= wr_word;
        end
    end

    // Fields packed line-major: line n sits at bits n*4 +: 4
    generate
        for (genvar w = 0; w < ASSIGN_WORDS; w++) begin : g_pack
            assign assign_flat[w*32 +: 32] = asg_q[w];
        end
    endgenerate

    // Pending lines are those both high and unmasked
    assign pending = status_q & mask_q;

    // Read multiplexer over the bank's slots
    always_comb begin
        case (sel)
            SEL_MASK:   rd_word = mask_q;
            SEL_ASG0:   rd_word = asg_q[0];
            SEL_ASG1:   rd_word = asg_q[1];
            SEL_ASG2:   rd_word = asg_q[2];
            SEL_ASG3:   rd_word = asg_q[3];
            SEL_STATUS: rd_word = status_q;
            SEL_WAKE:   rd_word = wake_q;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/irq_group_route.sv
// Module: routes pending lines of all banks onto the nine core groups.
// A line joins group g when its 4-bit field equals g; values 9..15 match
// nothing. Output is registered. Assumes fields are packed line-major.
module irq_group_route
    import irq_router_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] pending,
    input  logic [NUM_BANKS*FIELD_BITS-1:0] field_flat,
    output logic [GROUP_COUNT-1:0]          grp_q
);

    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    logic [GROUP_COUNT-1:0] grp_d;

    generate
        for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
            logic [NUM_LINES-1:0] match;
            // Mark every pending line whose field names this group
            always_comb begin
                for (int i = 0; i < NUM_LINES; i++)
                    match[i] = pending[i] && (field_flat[i*FIELD_W +: FIELD_W] == FIELD_W'(g));
            end
            assign grp_d[g] = |match;
        end
    endgenerate

    // Register the group requests toward the core
    always_ff @(posedge clk) begin
        if (!rst_n) grp_q <= '0;
        else        grp_q <= grp_d;
    end

endmodule

// File: rtl/irq_bus_decode.sv
// Module: register bus front end. Checks access width and alignment,
// splits the word index into control words and bank windows, steers the
// write strobe and returns a registered read word and error flag one cycle
// after each request. Assumes single-cycle requests.
module irq_bus_decode
    import irq_router_pkg::*;
#(
    parameter int          NUM_BANKS = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [15:0] REV_ID    = 16'h0A51
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [1:0]                  bus_size,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic [NUM_BANKS-1:0][31:0]  bank_rd,
    output logic [NUM_BANKS-1:0]        bank_wr,
    output bank_sel_e                   bank_sel,
    output logic [31:0]                 wr_word,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_err
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam int BIDX_W = WIDX_W - 3;

    acc_size_e         sz;
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] rel;
    logic [BIDX_W-1:0] bidx;
    logic              acc_ok;
    logic              is_ctrl;
    logic              bank_hit;
    logic [31:0]       rd_word;
    logic [31:0]       rd_shaped;

    // Address split and access legality
    assign sz       = acc_size_e'(bus_size);
    assign widx     = bus_addr[ADDR_W-1:2];
    assign rel      = widx - WIDX_W'(CTRL_WORDS);
    assign bidx     = rel[WIDX_W-1:3];
    assign bank_sel = bank_sel_e'(rel[2:0]);
    assign is_ctrl  = widx < WIDX_W'(CTRL_WORDS);
    assign bank_hit = !is_ctrl && (bidx < BIDX_W'(NUM_BANKS));
    assign acc_ok   = ((sz == SZ_HALF) || (sz == SZ_WORD)) && (bus_addr[1:0] == 2'b00);

    // 16-bit writes are zero-extended to the full register
    assign wr_word = (sz == SZ_HALF) ? {16'h0, bus_wdata[15:0]} : bus_wdata;

    // One write strobe per bank window
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
            assign bank_wr[b] = bus_valid && bus_write && acc_ok && bank_hit
                                && (bidx == BIDX_W'(b));
        end
    endgenerate

    // Select the read word from control space or the addressed bank
    always_comb begin
        rd_word = '0;
        if (is_ctrl && (widx == WIDX_W'(REV_WORD)))
            rd_word = {16'h0, REV_ID};
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_hit && (bidx == BIDX_W'(b)))
                rd_word = bank_rd[b];
    end

    assign rd_shaped = (sz == SZ_HALF) ? {16'h0, rd_word[15:0]} : rd_word;

    // Registered response: error flag and read data one cycle after request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else if (bus_valid) begin
            bus_err   <= !acc_ok;
            bus_rdata <= (acc_ok && !bus_write) ? rd_shaped : '0;
        end else begin
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: top of the banked system interrupt router. Instantiates one
// register bank per 32 lines, the bus front end and the group router.
// Assumes NUM_BANKS in 1..3 and ADDR_W wide enough for all bank windows.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int          NUM_BANKS = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [15:0] REV_ID    = 16'h0A51
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_in,
    input  logic                               bus_valid,
    input  logic                               bus_write,
    input  logic [1:0]                         bus_size,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [31:0]                        bus_wdata,
    output logic [31:0]                        bus_rdata,
    output logic                               bus_err,
    output logic [GROUP_COUNT-1:0]             grp_out
);

    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    logic [NUM_BANKS-1:0][31:0]      bank_rd;
    logic [NUM_BANKS-1:0]            bank_wr;
    bank_sel_e                       bank_sel;
    logic [31:0]                     wr_word;
    logic [NUM_LINES-1:0]            pending_all;
    logic [NUM_BANKS*FIELD_BITS-1:0] field_all;

    irq_bus_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .REV_ID    (REV_ID)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bank_rd   (bank_rd),
        .bank_wr   (bank_wr),
        .bank_sel  (bank_sel),
        .wr_word   (wr_word),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            irq_bank_regs #(
                .BANK_ID (b)
            ) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .irq_lvl     (irq_in[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .wr_en       (bank_wr[b]),
                .sel         (bank_sel),
                .wr_word     (wr_word),
                .rd_word     (bank_rd[b]),
                .pending     (pending_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .assign_flat (field_all[b*FIELD_BITS +: FIELD_BITS])
            );
        end
    endgenerate

    irq_group_route #(
        .NUM_BANKS (NUM_BANKS)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending_all),
        .field_flat (field_all),
        .grp_q      (grp_out)
    );

endmodule

// File: rtl/irq_router_chk.sv
// Module: property checker for the router's ports, attached by bind.
// Assumes single-cycle bus requests and synchronous input levels.
module irq_router_chk #(
    parameter int NUM_LINES = 96
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [1:0]           bus_size,
    input logic [1:0]           bus_addr_lo,
    input logic [31:0]          bus_rdata,
    input logic                 bus_err,
    input logic [8:0]           grp_out
);

    logic [1:0] age;
    logic       acc_ok;

    // Count cycles since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assign acc_ok = ((bus_size == 2'd1) || (bus_size == 2'd2)) && (bus_addr_lo == 2'b00);

    AST_BAD_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !acc_ok) |=> bus_err);                                  // R10
    AST_GOOD_ACCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && acc_ok) |=> !bus_err);                                  // R10
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'h0));                                    // R10
    AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> (bus_rdata == 32'h0));                   // R10
    AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd2) && ($past(irq_in, 2) == '0)) |-> (grp_out == '0));     // R4
    AST_RESET_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((grp_out == '0) && !bus_err));                      // R8

endmodule

bind irq_router irq_router_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_size    (bus_size),
    .bus_addr_lo (bus_addr[1:0]),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .grp_out     (grp_out)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

    localparam int          NB  = 3;
    localparam int          NL  = NB * 32;
    localparam logic [15:0] REV = 16'h0A51;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_size = 2'd2;
    logic [7:0]    bus_addr = 8'h0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [8:0]    grp_out;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    irq_router #(.NUM_BANKS(NB), .ADDR_W(8), .REV_ID(REV)) u_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .grp_out(grp_out)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_mask [NB];
    logic [31:0] m_wake [NB];
    logic [31:0] m_asg  [NB][4];
    logic [NL-1:0] m_status;
    logic [8:0]  exp_out = '0;
    logic [31:0] exp_rd = '0;
    logic        exp_err = 1'b0;

    function automatic logic [31:0] model_word(input logic [7:0] a);
        int w;
        int r;
        w = int'(a) / 4;
        if (w < 3) return (w == 2) ? {16'h0, REV} : 32'h0;
        r = w - 3;
        if (r / 8 >= NB) return 32'h0;
        case (r % 8)
            0: return m_mask[r/8];
            1, 2, 3, 4: return m_asg[r/8][(r%8)-1];
            5: return m_status[(r/8)*32 +: 32];
            6: return m_wake[r/8];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [8:0] nx;
        logic [31:0] val;
        bit ok;
        int w;
        int r;
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_mask[b] = 32'h0;
                m_wake[b] = 32'hFFFF_FFFF;
            end
            m_asg[0][0] = 32'h2221_1000; m_asg[0][1] = 32'h4333_3332;
            m_asg[0][2] = 32'h5555_5444; m_asg[0][3] = 32'h6665_5555;
            for (int b = 1; b < NB; b++)
                for (int k = 0; k < 4; k++) m_asg[b][k] = 32'h0;
            m_status = '0; exp_out = '0; exp_rd = '0; exp_err = 1'b0;
        end else begin
            nx = '0;
            for (int b = 0; b < NB; b++)
                for (int n = 0; n < 32; n++)
                    if (m_status[b*32+n] && m_mask[b][n]) begin
                        int v;
                        v = int'((m_asg[b][n/8] >> ((n % 8) * 4)) & 32'hF);
                        if (v < 9) nx[v] = 1'b1;
                    end
            exp_err = 1'b0; exp_rd = '0;
            if (bus_valid) begin
                ok = (bus_size == 2'd1 || bus_size == 2'd2) && (bus_addr[1:0] == 2'b00);
                exp_err = !ok;
                if (ok && !bus_write) begin
                    exp_rd = model_word(bus_addr);
                    if (bus_size == 2'd1) exp_rd = exp_rd & 32'hFFFF;
                end
                if (ok && bus_write) begin
                    val = (bus_size == 2'd1) ? (bus_wdata & 32'hFFFF) : bus_wdata;
                    w = int'(bus_addr) / 4;
                    if (w >= 3) begin
                        r = w - 3;
                        if (r / 8 < NB) begin
                            if (r % 8 == 0) m_mask[r/8] = val;
                            else if (r % 8 <= 4) m_asg[r/8][(r%8)-1] = val;
                            else if (r % 8 == 6) m_wake[r/8] = val;
                        end
                    end
                end
            end
            exp_out = nx;
            m_status = irq_in;
        end
        started = 1'b1;
    end

    // Compare against the reference on every cycle, away from the edge
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (grp_out !== exp_out) begin
                errors++;
                $display("FAIL R5 R7 R13 grp_out got %h exp %h at %0t", grp_out, exp_out, $time);
            end
            checks++;
            if (bus_err !== exp_err || bus_rdata !== exp_rd) begin
                errors++;
                $display("FAIL R10 R12 response got err=%0b data=%h exp err=%0b data=%h",
                         bus_err, bus_rdata, exp_err, exp_rd);
            end
        end
    end

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d, output logic [31:0] rd, output logic e);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd = bus_rdata; e = bus_err;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        access(1'b0, a, sz, 32'h0, d, e);
        check32(tag, d, exp);
    endtask

    task automatic wr_do(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] v);
        logic [31:0] d;
        logic e;
        access(1'b1, a, sz, v, d, e);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic e;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R8 reset state
        check32("R8 grp_out after reset", {23'h0, grp_out}, 32'h0);
        rd_chk("R8 mask0 reset", 8'h0C, 2'd2, 32'h0);
        rd_chk("R8 wake0 reset", 8'h24, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R8 assign0 word0 reset", 8'h10, 2'd2, 32'h2221_1000);
        rd_chk("R8 assign0 word3 reset", 8'h1C, 2'd2, 32'h6665_5555);
        rd_chk("R8 bank1 assign reset", 8'h30, 2'd2, 32'h0);
        rd_chk("R8 status0 reset", 8'h20, 2'd2, 32'h0);

        // R2 status follows the level
        irq_in[5] = 1'b1;
        settle(1);
        rd_chk("R2 status set", 8'h20, 2'd2, 32'h0000_0020);
        irq_in[5] = 1'b0;
        settle(1);
        rd_chk("R2 status clear", 8'h20, 2'd2, 32'h0);

        // R4 masked line raises nothing; R5 R7 routing and timing
        irq_in[5] = 1'b1;
        settle(3);
        check32("R4 masked line quiet", {23'h0, grp_out}, 32'h0);
        wr_do(8'h0C, 2'd2, 32'h0000_0020);
        check32("R7 no change in write cycle", {23'h0, grp_out}, 32'h0);
        settle(1);
        check32("R5 R7 line5 to group 9", {23'h0, grp_out}, 32'h004);
        irq_in[30] = 1'b1;
        wr_do(8'h0C, 2'd2, 32'h4000_0020);
        settle(3);
        check32("R5 line30 to group 13", {23'h0, grp_out}, 32'h044);

        // R6 out-of-range assignment values
        wr_do(8'h10, 2'd2, 32'h2291_1000);
        settle(2);
        check32("R6 value 9 routes nowhere", {23'h0, grp_out}, 32'h040);
        wr_do(8'h10, 2'd2, 32'h22F1_1000);
        settle(2);
        check32("R6 value 15 routes nowhere", {23'h0, grp_out}, 32'h040);

        // R3 status is read-only
        access(1'b1, 8'h20, 2'd2, 32'hFFFF_FFFF, d, e);
        check32("R3 status write no error", {31'h0, e}, 32'h0);
        rd_chk("R3 status unchanged", 8'h20, 2'd2, 32'h4000_0020);

        // R10 illegal widths and alignment
        access(1'b1, 8'h0C, 2'd0, 32'h0, d, e);
        check32("R10 byte write flagged", {31'h0, e}, 32'h1);
        rd_chk("R10 byte write ignored", 8'h0C, 2'd2, 32'h4000_0020);
        access(1'b0, 8'h24, 2'd3, 32'h0, d, e);
        check32("R10 reserved size flagged", {31'h0, e}, 32'h1);
        check32("R10 reserved size data", d, 32'h0);
        access(1'b0, 8'h0E, 2'd2, 32'h0, d, e);
        check32("R10 misaligned flagged", {31'h0, e}, 32'h1);

        // R11 16-bit accesses
        wr_do(8'h24, 2'd1, 32'hABCD_1234);
        rd_chk("R11 half write zero-extends", 8'h24, 2'd2, 32'h0000_1234);
        rd_chk("R11 half read low bits", 8'h14, 2'd1, 32'h0000_3332);

        // R12 control and unmapped space; R9 layout
        rd_chk("R12 unused slot", 8'h28, 2'd2, 32'h0);
        wr_do(8'h28, 2'd2, 32'h5);
        rd_chk("R12 unused slot after write", 8'h28, 2'd2, 32'h0);
        rd_chk("R12 beyond last bank", 8'h6C, 2'd2, 32'h0);
        rd_chk("R12 control word 0", 8'h00, 2'd2, 32'h0);
        rd_chk("R12 revision word", 8'h08, 2'd2, {16'h0, REV});

        // R1 R9 third bank registers and status
        wr_do(8'h4C, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R1 R9 bank2 mask", 8'h4C, 2'd2, 32'hFFFF_FFFF);
        irq_in = '0;
        irq_in[71] = 1'b1;
        settle(1);
        rd_chk("R1 bank2 status", 8'h60, 2'd2, 32'h0000_0080);

        // R13 lines of two banks share one group
        irq_in = '0;
        wr_do(8'h2C, 2'd2, 32'h1);
        wr_do(8'h30, 2'd2, 32'h4);
        wr_do(8'h5C, 2'd2, 32'h4000_0000);
        irq_in[32] = 1'b1;
        irq_in[95] = 1'b1;
        settle(3);
        check32("R13 two banks to group 11", {23'h0, grp_out}, 32'h010);
        irq_in[32] = 1'b0;
        settle(3);
        check32("R13 remaining line holds group", {23'h0, grp_out}, 32'h010);
        irq_in[95] = 1'b0;
        settle(3);
        check32("R2 R13 all low", {23'h0, grp_out}, 32'h0);

        // Random phase: per-cycle comparison covers R5 R7 R13
        for (int it = 0; it < 400; it++) begin
            if (($urandom % 4) == 0) begin
                int b;
                int s;
                b = int'($urandom % NB);
                s = int'($urandom % 5);
                wr_do(8'(12 + 32 * b + 4 * s), 2'd2, $urandom);
            end else begin
                irq_in = {$urandom, $urandom, $urandom};
                settle(1);
            end
        end
        settle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule